// File: doc/BRIEF.md
# Pipelined Phase Accumulator Core

This block is the phase engine of a numerically controlled oscillator. A 32-bit tuning word sets the phase increment. On every clock on which stepping is enabled, a 32-bit accumulator adds the contents of a staging register to itself and wraps modulo 2^32. The top 13 bits of the accumulator leave the block as the phase, which a downstream amplitude stage maps to a waveform. The output frequency is the tuning word times the clock frequency divided by 2^32. For example, a word of 0x2000_0000 gives a phase that repeats every 8 clocks.

Three active-low controls steer the block. Capture copies the tuning word into the staging register. Advance lets the accumulator step. Preset zeroes the feedback term, so that the accumulator takes the staging register value directly. Each control first passes through its own fixed delay line, which resets to the inactive (high) level. Capture and advance take effect 4 clocks after they are sampled, and preset takes effect after 5. Inside the accumulator, a decoder names the action for each cycle: HOLD (no preset, no advance), STEP (advance without preset) or LOAD (preset, with or without advance). LOAD has priority over STEP, and STEP has priority over HOLD. The decoder returns to its choice every cycle, so any state can go to any other in one clock.

Top module: `nco_phase_core`

## Requirements
- R1: After reset the accumulator and the staging register hold zero and `phase` reads 0. All three controls act as inactive until a low level has travelled through its delay line.
- R2: A low on `capture_n` sampled at clock edge k loads the staging register at edge k+4, with the value `tune_word` has at that edge. A high on `capture_n` leaves the staging register unchanged, and a later preset still loads the old value.
- R3: A low on `advance_n` sampled at edge k lets the accumulator step at edge k+4. While the delayed advance is high and no preset acts, the accumulator holds its value. This applies to a single-cycle low as well.
- R4: A low on `preset_n` sampled at edge k makes the accumulator equal to the staging register at edge k+5, because the feedback term is zeroed.
- R5: Each step sets the accumulator to its previous value plus the staging register, modulo 2^32.
- R6: A preset that acts while advance is also active gives the staging register value, not the sum. A preset also acts while advance is inactive.
- R7: `phase` equals accumulator bits 31..19 in the same cycle, with no extra register. For a word W, after a preset and n steps, `phase` is bits 31..19 of (n+1)*W mod 2^32.
- R8: When a capture and a preset act on the same edge, the accumulator takes the staging register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 32 | Phase increment offered to the staging register |
| capture_n | input | 1 | Active-low capture of `tune_word` (4-clock delay) |
| preset_n | input | 1 | Active-low feedback zeroing (5-clock delay) |
| advance_n | input | 1 | Active-low step enable (4-clock delay) |
| phase | output | 13 | Top 13 accumulator bits |

## Verification
The hardest case to reach from the ports is a capture and a preset acting on the same edge. Because the two delays differ by one clock, the stimulus has to issue the preset one cycle before the capture. Before that, the accumulator is stepped away from the staging value so the two outcomes can be told apart. A second hard case is a preset that lands in the middle of a stepping run, while advance is still active in its delay line. The stimulus stops the run early and counts the steps that are still in flight, so it can predict the value after the run.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_STEP = 2'd1,
        ACC_LOAD = 2'd2
    } acc_act_e;
endpackage

// File: rtl/nco_ctl_delay.sv
`timescale 1ns/1ps
module nco_ctl_delay #(
    parameter int DEPTH   = 4,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [DEPTH-1:0] sr;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sr <= {DEPTH{RST_VAL}};
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < DEPTH; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/nco_tune_reg.sv
`timescale 1ns/1ps
module nco_tune_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grab,
    input  logic [W-1:0] word,
    output logic [W-1:0] held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (grab) begin
            held <= word;
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero_fb,
    input  logic         stepping,
    input  logic [W-1:0] incr,
    output logic [W-1:0] acc
);
    acc_act_e     act;
    logic [W-1:0] acc_nxt;

    // action decode: preset outranks advance
    always_comb begin
        if (zero_fb) begin
            act = ACC_LOAD;
        end else if (stepping) begin
            act = ACC_STEP;
        end else begin
            act = ACC_HOLD;
        end
    end

    always_comb begin
        unique case (act)
            ACC_LOAD: acc_nxt = incr;
            ACC_STEP: acc_nxt = acc + incr;
            ACC_HOLD: acc_nxt = acc;
            default:  acc_nxt = acc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc_nxt;
        end
    end
endmodule

// File: rtl/nco_phase_core.sv
`timescale 1ns/1ps
module nco_phase_core #(
    parameter int ACC_W     = 32,
    parameter int PHASE_W   = 13,
    parameter int XFER_LAT  = 4,
    parameter int ADV_LAT   = 4,
    parameter int PRE_LAT   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   tune_word,
    input  logic               capture_n,
    input  logic               preset_n,
    input  logic               advance_n,
    output logic [PHASE_W-1:0] phase
);
    localparam int PHASE_LSB = ACC_W - PHASE_W;

    logic cap_dn, pre_dn, adv_dn;
    logic xfer_act, load_act, step_act;
    logic [ACC_W-1:0] inreg;
    logic [ACC_W-1:0] acc;

    nco_ctl_delay #(.DEPTH(XFER_LAT), .RST_VAL(1'b1)) i_cap_dly (
        .clk(clk), .rst_n(rst_n), .d(capture_n), .q(cap_dn));
    nco_ctl_delay #(.DEPTH(PRE_LAT), .RST_VAL(1'b1)) i_pre_dly (
        .clk(clk), .rst_n(rst_n), .d(preset_n), .q(pre_dn));
    nco_ctl_delay #(.DEPTH(ADV_LAT), .RST_VAL(1'b1)) i_adv_dly (
        .clk(clk), .rst_n(rst_n), .d(advance_n), .q(adv_dn));

    assign xfer_act = ~cap_dn;
    assign load_act = ~pre_dn;
    assign step_act = ~adv_dn;

    nco_tune_reg #(.W(ACC_W)) i_tune (
        .clk(clk), .rst_n(rst_n), .grab(xfer_act),
        .word(tune_word), .held(inreg));

    nco_phase_acc #(.W(ACC_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .zero_fb(load_act),
        .stepping(step_act), .incr(inreg), .acc(acc));

    assign phase = acc[ACC_W-1:PHASE_LSB];
endmodule

// File: rtl/nco_phase_core_chk.sv
`timescale 1ns/1ps
module nco_phase_core_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_act,
    input logic             load_act,
    input logic             step_act,
    input logic [ACC_W-1:0] inreg,
    input logic [ACC_W-1:0] acc
);
    assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_act |=> acc == $past(inreg));

    assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_act && step_act) |=> acc == $past(acc) + $past(inreg));

    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_act && !step_act) |=> $stable(acc));

    assert_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_act |=> $stable(inreg));
endmodule

bind nco_phase_core nco_phase_core_chk #(.ACC_W(ACC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .xfer_act(xfer_act), .load_act(load_act),
    .step_act(step_act), .inreg(inreg), .acc(acc));

// File: tb/test_nco_phase_core.sv
`timescale 1ns/1ps
module test_nco_phase_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tune_word = '0;
    logic        capture_n = 1'b1;
    logic        preset_n = 1'b1;
    logic        advance_n = 1'b1;
    logic [12:0] phase;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_acc = '0;
    logic [31:0] exp_in = '0;

    always #4 clk = ~clk;

    nco_phase_core i_nco_phase_core (
        .clk(clk), .rst_n(rst_n), .tune_word(tune_word),
        .capture_n(capture_n), .preset_n(preset_n),
        .advance_n(advance_n), .phase(phase));

    function automatic logic [12:0] top13(input logic [31:0] a);
        return a[31:19];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [12:0] exp);
        checks++;
        if (phase !== exp) begin
            errors++;
            $display("FAIL %s: phase=%h expected=%h", req, phase, exp);
        end
    endtask

    // one tick; optionally the accumulator steps by the staging value
    task automatic step_tick(input bit steps, input string req);
        tick();
        if (steps) exp_acc = exp_acc + exp_in;
        chk(req, top13(exp_acc));
    endtask

    function automatic logic [31:0] sweep_word(input int idx);
        case (idx)
            0: return 32'h0008_0000;
            1: return 32'hFFF8_0000;
            2: return 32'h8000_0000;
            3: return 32'h1234_5678;
            4: return 32'h0000_0001;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1", 13'h0);
        for (int i = 0; i < 6; i++) step_tick(1'b0, "R1");

        // R2/R4 latency: capture and preset together at edge k
        tune_word = 32'h2000_0000;
        capture_n = 1'b0; preset_n = 1'b0;
        tick();
        capture_n = 1'b1; preset_n = 1'b1;
        chk("R4", 13'h0);
        for (int m = 1; m <= 4; m++) begin
            tick();
            chk("R4", 13'h0);
        end
        tick();
        exp_in = 32'h2000_0000; exp_acc = exp_in;
        chk("R4", 13'h0400);

        // R3 latency, R5 wrap, R7 period of 8
        advance_n = 1'b0;
        for (int m = 0; m < 4; m++) step_tick(1'b0, "R3");
        for (int n = 0; n < 13; n++) step_tick(1'b1, "R5");
        advance_n = 1'b1;
        for (int m = 0; m < 4; m++) step_tick(1'b1, "R3");
        for (int m = 0; m < 8; m++) step_tick(1'b0, "R3");
        chk("R7", 13'h0800);

        // R8: preset sampled one edge before capture, both act on one edge
        tune_word = 32'h6000_0000;
        preset_n = 1'b0;
        tick();
        preset_n = 1'b1; capture_n = 1'b0;
        tick();
        capture_n = 1'b1;
        tick(); tick(); tick();
        chk("R8", top13(exp_acc));
        tick();
        exp_acc = exp_in;
        chk("R8", 13'h0400);
        exp_in = 32'h6000_0000;

        // R2: preset now yields the captured word
        preset_n = 1'b0;
        tick();
        preset_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            tick();
            chk("R2", 13'h0400);
        end
        tick();
        exp_acc = exp_in;
        chk("R2", 13'h0C00);

        // R3: single-cycle advance gives exactly one step
        advance_n = 1'b0;
        tick();
        advance_n = 1'b1;
        chk("R3", top13(exp_acc));
        for (int m = 1; m < 4; m++) step_tick(1'b0, "R3");
        step_tick(1'b1, "R3");
        for (int m = 0; m < 5; m++) step_tick(1'b0, "R3");

        // R2: word changes without capture, preset keeps old staging value
        tune_word = 32'h7FF0_0000;
        preset_n = 1'b0;
        tick();
        preset_n = 1'b1;
        for (int m = 0; m < 4; m++) step_tick(1'b0, "R2");
        tick();
        exp_acc = exp_in;
        chk("R2", 13'h0C00);

        // R6: preset during a stepping run wins over the step
        advance_n = 1'b0;
        for (int m = 0; m < 4; m++) step_tick(1'b0, "R6");
        for (int m = 0; m < 4; m++) step_tick(1'b1, "R6");
        preset_n = 1'b0;
        step_tick(1'b1, "R6");
        preset_n = 1'b1;
        for (int m = 0; m < 4; m++) step_tick(1'b1, "R6");
        tick();
        exp_acc = exp_in;
        chk("R6", top13(exp_acc));
        step_tick(1'b1, "R6");
        advance_n = 1'b1;
        for (int m = 0; m < 4; m++) step_tick(1'b1, "R6");
        for (int m = 0; m < 3; m++) step_tick(1'b0, "R6");
        // R6: preset acting while advance is inactive
        exp_acc = exp_acc + exp_in;
        preset_n = 1'b0;
        tick();
        preset_n = 1'b1;
        exp_acc = exp_acc - exp_in;
        chk("R6", top13(exp_acc));
        for (int m = 1; m < 5; m++) step_tick(1'b0, "R6");
        tick();
        exp_acc = exp_in;
        chk("R6", top13(exp_acc));

        // R7/R5 sweep over several tuning words
        for (int w = 0; w < 6; w++) begin
            tune_word = sweep_word(w);
            capture_n = 1'b0; preset_n = 1'b0;
            tick();
            capture_n = 1'b1; preset_n = 1'b1;
            for (int m = 0; m < 5; m++) tick();
            exp_in = sweep_word(w); exp_acc = exp_in;
            chk("R7", top13(exp_acc));
            advance_n = 1'b0;
            for (int m = 0; m < 4; m++) step_tick(1'b0, "R7");
            for (int n = 0; n < 40; n++) step_tick(1'b1, "R7");
            advance_n = 1'b1;
            for (int m = 0; m < 4; m++) step_tick(1'b1, "R7");
            step_tick(1'b0, "R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule